// File: doc/BRIEF.md
# Set/Clear GPIO Pin Bank

This block is a bank of general-purpose pins controlled through a small word-addressed register bus. The bus has a write port and an independent read port. Output data and pin direction are never written as whole words. Software changes them only through strobe words: a one in a bit position sets or clears that pin, and a zero leaves it alone. Several pins can therefore be updated without a read-modify-write.

Each pin also carries a two-bit function select built from two separate select words, a pull-disable bit and a sleep-keep bit. The block drives the pad output value, output enable and pull enable, and it presents the function select and the sleep-keep bit for every pin. Pad input levels pass through a two-stage synchronizer before software can read them.

Word map (4-bit word address): 0 input levels (read only), 1 data set, 2 data clear, 3 direction (read only), 4 direction set, 5 direction clear, 6 select A, 7 select B, 8 pull disable, 9 sleep keep. Words 10 to 15 are unmapped.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every register is zero: pad_out and pad_oe are all 0, pad_pull_en is all 1, pad_fsel is all 0 (plain GPIO), sleep_keep is all 0, and the direction word reads 0.
- R2: A write to word 1 sets pad_out for each bit written as 1 after the clock edge that takes the write. Bits written as 0 keep their value.
- R3: A write to word 2 clears pad_out for each bit written as 1 after the clock edge that takes the write. Bits written as 0 keep their value.
- R4: A write to word 4 makes the pins written as 1 outputs, and a write to word 5 makes them inputs. pad_oe equals the direction state, and word 3 reads it back with 1 meaning output.
- R5: Word 0 reads pad_in as it was two clock edges earlier. A change on pad_in is not visible after one edge, and it is visible after two.
- R6: Words 6 (A) and 7 (B) are read/write. The 2-bit field pad_fsel[2i+1:2i] equals {B[i],A[i]}, where 00 is plain GPIO, 01 is function A, 10 is function B and 11 is function C.
- R7: Word 8 is read/write. pad_pull_en[i] is 1 exactly when bit i of word 8 is 0.
- R8: Word 9 is read/write and drives sleep_keep bit for bit. A 1 keeps the pin's state in sleep, and a 0 allows wakeup behaviour.
- R9: Strobe words 1, 2, 4 and 5 read as 0. Writes to word 0 and to words 10 to 15 change no output and no readable word.
- R10: A read of a word in the same cycle as a write that changes it returns the old contents. The new contents appear from the next cycle on.
- R11: The data state is kept while a pin is an input. pad_out shows it regardless of direction, and it is still in place when the pin later becomes an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_waddr | input | 4 | Write word address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4 | Read word address |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pad pull enables |
| pad_fsel | output | 64 | Function select, 2 bits per pin |
| sleep_keep | output | 32 | Per-pin sleep keep control |

## Verification
Because the read port is independent of the write port, a read can land in the same cycle as a write that changes the word being read. The direction, select and pull words are each read in the cycle their write is presented, and then again one cycle later. The first read must return the old contents and the second the new ones. A second overlap is an input change that arrives while the level word is being read: the bench samples the word after one edge and after two, and expects the old level and then the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] W_LEVEL   = 4'd0;
  localparam logic [ADDR_W-1:0] W_DSET    = 4'd1;
  localparam logic [ADDR_W-1:0] W_DCLR    = 4'd2;
  localparam logic [ADDR_W-1:0] W_DIR     = 4'd3;
  localparam logic [ADDR_W-1:0] W_DIRSET  = 4'd4;
  localparam logic [ADDR_W-1:0] W_DIRCLR  = 4'd5;
  localparam logic [ADDR_W-1:0] W_SELA    = 4'd6;
  localparam logic [ADDR_W-1:0] W_SELB    = 4'd7;
  localparam logic [ADDR_W-1:0] W_PULLOFF = 4'd8;
  localparam logic [ADDR_W-1:0] W_SLEEP   = 4'd9;

  typedef enum logic [1:0] {
    MODE_GPIO = 2'b00,
    MODE_FA   = 2'b01,
    MODE_FB   = 2'b10,
    MODE_FC   = 2'b11
  } pin_mode_e;

  function automatic pin_mode_e pack_mode(input logic sel_b, input logic sel_a);
    return pin_mode_e'({sel_b, sel_a});
  endfunction
endpackage

// File: rtl/gpio_strobe_reg.sv
module gpio_strobe_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_bits(input logic [W-1:0] cur,
                                             input logic [W-1:0] s,
                                             input logic [W-1:0] c);
    return (cur | s) & ~c;
  endfunction

  logic [W-1:0] q_next;
  assign q_next = next_bits(q, set_mask, clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R2 / R4: bits named in a set strobe are 1 after the edge
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

  // R3 / R4: bits named in a clear strobe are 0 after the edge
  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((q & $past(clr_mask)) == '0));

  // R2 / R3: bits not named in any strobe hold
  p_untouched_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(set_mask | clr_mask)) == '0));
endmodule

// File: rtl/gpio_rw_reg.sv
module gpio_rw_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  // R6 / R7 / R8: the stored word does not move without a write
  p_hold_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (q == $past(q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];

  // Cycles since reset, saturating, so the latency check never looks into reset
  localparam int unsigned WARM_W = $clog2(STAGES + 2);
  localparam logic [WARM_W-1:0] WARM_MAX = WARM_W'(STAGES);
  logic [WARM_W-1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm <= '0;
    else if (warm != WARM_MAX) warm <= warm + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_two
      // R5: output equals the input two edges earlier
      p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == WARM_MAX) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_mode_map.sv
module gpio_mode_map
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]   sel_a,
  input  logic [N-1:0]   sel_b,
  output logic [2*N-1:0] fsel
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      pin_mode_e mode;
      assign mode = pack_mode(sel_b[i], sel_a[i]);
      assign fsel[2*i +: 2] = mode;
    end
  endgenerate
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_waddr,
  input  logic [NPINS-1:0]     bus_wdata,
  input  logic [ADDR_W-1:0]    bus_raddr,
  output logic [NPINS-1:0]     bus_rdata,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_pull_en,
  output logic [2*NPINS-1:0]   pad_fsel,
  output logic [NPINS-1:0]     sleep_keep
);
  localparam int unsigned N_RW = 4;

  function automatic logic [NPINS-1:0] strobe_for(input logic wr,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] target,
                                                  input logic [NPINS-1:0] d);
    return (wr && a == target) ? d : '0;
  endfunction

  // Named write events
  logic [NPINS-1:0] dset_stb, dclr_stb, dirset_stb, dirclr_stb;
  assign dset_stb   = strobe_for(bus_wr, bus_waddr, W_DSET,   bus_wdata);
  assign dclr_stb   = strobe_for(bus_wr, bus_waddr, W_DCLR,   bus_wdata);
  assign dirset_stb = strobe_for(bus_wr, bus_waddr, W_DIRSET, bus_wdata);
  assign dirclr_stb = strobe_for(bus_wr, bus_waddr, W_DIRCLR, bus_wdata);

  logic [NPINS-1:0] dout_q, dir_q, level_q;

  gpio_strobe_reg #(.W(NPINS)) u_dout (
    .clk(clk), .rst_n(rst_n), .set_mask(dset_stb), .clr_mask(dclr_stb), .q(dout_q));

  gpio_strobe_reg #(.W(NPINS)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_mask(dirset_stb), .clr_mask(dirclr_stb), .q(dir_q));

  // Plain read/write words: select A, select B, pull disable, sleep keep
  localparam logic [ADDR_W-1:0] RW_ADDR [N_RW] = '{W_SELA, W_SELB, W_PULLOFF, W_SLEEP};
  logic [NPINS-1:0] rw_q  [N_RW];
  logic             rw_we [N_RW];

  generate
    for (genvar r = 0; r < N_RW; r++) begin : g_rw
      assign rw_we[r] = bus_wr && (bus_waddr == RW_ADDR[r]);
      gpio_rw_reg #(.W(NPINS)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(rw_we[r]), .wdata(bus_wdata), .q(rw_q[r]));
    end
  endgenerate

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(level_q));

  gpio_mode_map #(.N(NPINS)) u_mode (
    .sel_a(rw_q[0]), .sel_b(rw_q[1]), .fsel(pad_fsel));

  assign pad_out     = dout_q;
  assign pad_oe      = dir_q;
  assign pad_pull_en = ~rw_q[2];
  assign sleep_keep  = rw_q[3];

  // Read port
  always_comb begin
    unique case (bus_raddr)
      W_LEVEL:   bus_rdata = level_q;
      W_DIR:     bus_rdata = dir_q;
      W_SELA:    bus_rdata = rw_q[0];
      W_SELB:    bus_rdata = rw_q[1];
      W_PULLOFF: bus_rdata = rw_q[2];
      W_SLEEP:   bus_rdata = rw_q[3];
      default:   bus_rdata = '0;
    endcase
  end

  // R4: direction read-back agrees with the output enables
  p_dir_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == W_DIR) |-> (bus_rdata == pad_oe));

  // R7: pull-disable read-back is the complement of the pull enables
  p_pull_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == W_PULLOFF) |-> (bus_rdata == ~pad_pull_en));

  // R9: strobe words read as zero
  p_strobe_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == W_DSET || bus_raddr == W_DCLR ||
     bus_raddr == W_DIRSET || bus_raddr == W_DIRCLR) |-> (bus_rdata == '0));

  // R11: pad_out moves only on data strobes, never on direction writes
  p_data_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((dset_stb | dclr_stb) == '0) |=> (pad_out == $past(pad_out)));
endmodule

// File: tb/gpio_setclr_bank_tb.sv
module gpio_setclr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pull_en, sleep_keep;
  logic [63:0] pad_fsel;

  int n_chk = 0;
  int n_bad = 0;

  // Expected state
  logic [31:0] e_dout = '0, e_dir = '0, e_a = '0, e_b = '0, e_poff = '0, e_slp = '0;

  always #4 clk = ~clk;

  gpio_setclr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_fsel(pad_fsel), .sleep_keep(sleep_keep));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_fsel(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] f;
    for (int i = 0; i < 32; i++) begin
      f[2*i]   = a[i];
      f[2*i+1] = b[i];
    end
    return f;
  endfunction

  // One write; returns at the negedge after the edge that took it
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_waddr = 4'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    chk(req, "pad_out", {32'd0, pad_out}, {32'd0, e_dout});
    chk(req, "pad_oe", {32'd0, pad_oe}, {32'd0, e_dir});
    chk(req, "pad_pull_en", {32'd0, pad_pull_en}, {32'd0, ~e_poff});
    chk(req, "pad_fsel", pad_fsel, exp_fsel(e_a, e_b));
    chk(req, "sleep_keep", {32'd0, sleep_keep}, {32'd0, e_slp});
    rd(4'd3, v); chk(req, "dir word", {32'd0, v}, {32'd0, e_dir});
    rd(4'd6, v); chk(req, "sel A word", {32'd0, v}, {32'd0, e_a});
    rd(4'd7, v); chk(req, "sel B word", {32'd0, v}, {32'd0, e_b});
    rd(4'd8, v); chk(req, "pull-off word", {32'd0, v}, {32'd0, e_poff});
    rd(4'd9, v); chk(req, "sleep word", {32'd0, v}, {32'd0, e_slp});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_data_set();
    wr(4'd1, 32'h0000_00F3); e_dout |= 32'h0000_00F3;
    check_all("R2");
    wr(4'd1, 32'h8000_0100); e_dout |= 32'h8000_0100;
    check_all("R2");
  endtask

  task automatic t_data_clear();
    wr(4'd2, 32'h0000_0011); e_dout &= ~32'h0000_0011;
    check_all("R3");
    wr(4'd2, 32'h0000_0000);
    check_all("R3");
  endtask

  task automatic t_dir();
    wr(4'd4, 32'hFFFF_0000); e_dir |= 32'hFFFF_0000;
    check_all("R4");
    wr(4'd5, 32'h0F0F_0000); e_dir &= ~32'h0F0F_0000;
    check_all("R4");
  endtask

  task automatic t_levels();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'hA5A5_5A5A;
    @(negedge clk);
    rd(4'd0, v); chk("R5", "level after one edge", {32'd0, v}, 64'd0);
    @(negedge clk);
    rd(4'd0, v); chk("R5", "level after two edges", {32'd0, v}, {32'd0, 32'hA5A5_5A5A});
    pad_in = 32'h0000_FFFF;
    @(negedge clk);
    rd(4'd0, v); chk("R5", "level holds after one edge", {32'd0, v}, {32'd0, 32'hA5A5_5A5A});
    @(negedge clk);
    rd(4'd0, v); chk("R5", "level second pattern", {32'd0, v}, {32'd0, 32'h0000_FFFF});
  endtask

  task automatic t_modes();
    // pins 0..3 -> GPIO, A, B, C
    wr(4'd6, 32'h0000_000A); e_a = 32'h0000_000A;
    wr(4'd7, 32'h0000_000C); e_b = 32'h0000_000C;
    check_all("R6");
    chk("R6", "pin1 function A", {62'd0, pad_fsel[3:2]}, 64'd1);
    chk("R6", "pin3 function C", {62'd0, pad_fsel[7:6]}, 64'd3);
    wr(4'd6, 32'hFFFF_FFFF); e_a = 32'hFFFF_FFFF;
    check_all("R6");
  endtask

  task automatic t_pull_sleep();
    wr(4'd8, 32'h1234_5678); e_poff = 32'h1234_5678;
    check_all("R7");
    wr(4'd9, 32'h8765_4321); e_slp = 32'h8765_4321;
    check_all("R8");
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF);
    for (int a = 10; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    check_all("R9");
    rd(4'd1, v); chk("R9", "data set word reads 0", {32'd0, v}, 64'd0);
    rd(4'd2, v); chk("R9", "data clear word reads 0", {32'd0, v}, 64'd0);
    rd(4'd4, v); chk("R9", "dir set word reads 0", {32'd0, v}, 64'd0);
    rd(4'd5, v); chk("R9", "dir clear word reads 0", {32'd0, v}, 64'd0);
    rd(4'd12, v); chk("R9", "unmapped word reads 0", {32'd0, v}, 64'd0);
  endtask

  task automatic t_same_cycle(input logic [3:0] waddr, input logic [3:0] raddr,
                              input logic [31:0] d, input logic [31:0] old_v,
                              input logic [31:0] new_v);
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = waddr; bus_wdata = d; bus_raddr = raddr;
    #1; v = bus_rdata;
    chk("R10", "read during write is old", {32'd0, v}, {32'd0, old_v});
    @(negedge clk);
    bus_wr = 1'b0; bus_waddr = 4'd0; bus_wdata = '0;
    #1; v = bus_rdata;
    chk("R10", "read next cycle is new", {32'd0, v}, {32'd0, new_v});
  endtask

  task automatic t_kept();
    // pin 0 is an input holding data 1 in its latch
    wr(4'd5, 32'h0000_0001); e_dir &= ~32'h0000_0001;
    wr(4'd1, 32'h0000_0001); e_dout |= 32'h0000_0001;
    check_all("R11");
    wr(4'd4, 32'h0000_0001); e_dir |= 32'h0000_0001;
    check_all("R11");
    chk("R11", "pin0 drives latched 1", {63'd0, pad_out[0] & pad_oe[0]}, 64'd1);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data_set();
    t_data_clear();
    t_dir();
    t_levels();
    t_modes();
    t_pull_sleep();
    t_ignored();
    t_same_cycle(4'd4, 4'd3, 32'h0000_00F0, e_dir, e_dir | 32'h0000_00F0);
    e_dir |= 32'h0000_00F0;
    t_same_cycle(4'd7, 4'd7, 32'h5555_0000, e_b, 32'h5555_0000);
    e_b = 32'h5555_0000;
    t_same_cycle(4'd8, 4'd8, 32'h0000_0000, e_poff, 32'h0000_0000);
    e_poff = '0;
    check_all("R10");
    t_kept();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule